// File: doc/BRIEF.md
# Audio Transmit/Receive FIFO Status Unit

This block sits between the CPU side of a serial audio port and its serializer. It holds two word FIFOs. The first is a transmit FIFO that the CPU (or a DMA engine) fills and the serializer drains. The second is a receive FIFO that the serializer fills and the CPU drains. Each FIFO is eight 32-bit words deep.

A single 32-bit status word reports both fill levels and two sticky flags. The transmit-empty flag tells the producer that room is available. It sets whenever the transmit level drops to a programmable threshold or below. Software can clear it only once the level is back above that threshold, and an accepted DMA-sourced write clears it on its own. The receive-full flag tells the consumer that at least a threshold number of words are waiting.

A transmit request output mirrors the transmit-empty flag, so an interrupt or DMA controller can be wired to it directly. Thresholds arrive as 2-bit select inputs. Decoding them from a control register is done elsewhere. A pop from an empty transmit FIFO produces a one-cycle underflow pulse. A push into a full receive FIFO produces a one-cycle overflow pulse.

Top module: `audio_fifo_status`

## Requirements
- R1: The transmit FIFO stores up to 8 words in arrival order. `ser_tx_data` shows the oldest stored word. `stat_rdata[27:24]` gives the stored count (0 to 8), and an accepted write or pop changes it one clock after the edge on which it occurs.
- R2: A `cpu_tx_wr` made while the transmit count is 8 is dropped. The count stays 8 and the stored words are unchanged.
- R3: The receive FIFO stores up to 8 words in arrival order. `cpu_rx_rdata` shows the oldest word, or 0 when the FIFO is empty. `stat_rdata[11:8]` gives the count (0 to 8). A `cpu_rx_rd` made while the FIFO is empty changes nothing.
- R4: A `ser_rx_push` made while the receive count is 8 is dropped, and `ser_rx_overflow` is 1 for exactly the following cycle.
- R5: A `ser_tx_pop` made while the transmit FIFO is empty leaves the count at 0. `ser_tx_data` then shows the word most recently popped (0 if none has been popped since reset), and `ser_tx_underflow` is 1 for exactly the following cycle.
- R6: The transmit-empty flag is `stat_rdata[16]` and is 1 after reset. After every edge on which the new transmit count is at or below the threshold, the flag is 1. The threshold comes from `tx_trig_sel`: 0 gives 7, 1 gives 6, 2 gives 4 and 3 gives 2.
- R7: A status write with bit 16 equal to 0 clears the transmit-empty flag only when the transmit count at that edge is above the threshold and the count after the edge is also above it. Writing 1 to bit 16 never changes the flag.
- R8: An accepted transmit write with `cpu_tx_dma` set, after which the count is above the threshold, clears the transmit-empty flag with no status write.
- R9: `tx_req` always equals `stat_rdata[16]`.
- R10: The receive-full flag is `stat_rdata[0]` and is 0 after reset. It is 1 after every edge on which the new receive count is at or above the receive threshold. That threshold comes from `rx_trig_sel`: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 6. A status write with bit 0 equal to 0 clears the flag when the new count is below that threshold.
- R11: Every status bit other than 27:24, 16, 11:8 and 0 reads 0. Status writes affect only bits 16 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_tx_wr | input | 1 | Write one word into the transmit FIFO |
| cpu_tx_dma | input | 1 | Marks the current transmit write as DMA-sourced |
| cpu_tx_wdata | input | 32 | Transmit word to write |
| cpu_rx_rd | input | 1 | Pop the oldest receive word |
| cpu_rx_rdata | output | 32 | Oldest receive word, 0 when empty |
| stat_wr | input | 1 | Write strobe for the status word |
| stat_wdata | input | 32 | Status write data (only bits 16 and 0 act) |
| stat_rdata | output | 32 | Status word |
| tx_trig_sel | input | 2 | Transmit threshold select |
| rx_trig_sel | input | 2 | Receive threshold select |
| ser_tx_pop | input | 1 | Serializer takes the oldest transmit word |
| ser_tx_data | output | 32 | Oldest transmit word, or the last popped word when empty |
| ser_tx_underflow | output | 1 | One-cycle pulse after a pop from an empty FIFO |
| ser_rx_push | input | 1 | Serializer delivers one received word |
| ser_rx_data | input | 32 | Received word |
| ser_rx_overflow | output | 1 | One-cycle pulse after a push into a full FIFO |
| tx_req | output | 1 | Transmit request, equal to the transmit-empty flag |

## Verification
Every registered result is due one clock after the edge that sampled its stimulus: the counts, both flags and the two event pulses. The head-of-FIFO outputs `ser_tx_data` and `cpu_rx_rdata` are combinational from that registered state. The bench drives inputs on the falling edge and updates its reference model from the values presented before the rising edge. It compares every output on the next falling edge, so each check lands one edge after its cause. The expected flag outcome depends on the count both before and after the edge, so the model evaluates both.

// File: rtl/afs_pkg.sv
package afs_pkg;

    localparam int WORD_W  = 32;
    localparam int FIFO_DEPTH = 8;

    // Status word field positions (a software driver decodes these)
    localparam int TXCNT_LSB = 24;
    localparam int RXCNT_LSB = 8;
    localparam int TDE_BIT   = 16;
    localparam int RDF_BIT   = 0;
    localparam int FIELD_W   = 4;

    typedef struct packed {
        logic tde;
        logic rdf;
        logic unf;
        logic ovf;
    } afs_flags_t;

    function automatic logic [3:0] tx_thresh(input logic [1:0] sel);
        logic [3:0] t;
        case (sel)
            2'd0:    t = 4'd7;
            2'd1:    t = 4'd6;
            2'd2:    t = 4'd4;
            default: t = 4'd2;
        endcase
        return t;
    endfunction

    function automatic logic [3:0] rx_thresh(input logic [1:0] sel);
        logic [3:0] t;
        case (sel)
            2'd0:    t = 4'd1;
            2'd1:    t = 4'd2;
            2'd2:    t = 4'd4;
            default: t = 4'd6;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/afs_fifo.sv
module afs_fifo #(
    parameter int W         = 32,
    parameter int DEPTH     = 8,
    parameter bit HOLD_LAST = 1'b1,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int PW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_next
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr_ptr;
        logic [PW-1:0]           rd_ptr;
        logic [CW-1:0]           count;
        logic [W-1:0]            last;
    } fifo_state_t;

    fifo_state_t s_q, s_d;
    logic push_acc, pop_acc;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d      = s_q;
        push_acc = push && (s_q.count != CW'(DEPTH));
        pop_acc  = pop && (s_q.count != '0);
        if (pop_acc) begin
            s_d.last   = s_q.mem[s_q.rd_ptr];
            s_d.rd_ptr = ptr_inc(s_q.rd_ptr);
        end
        if (push_acc) begin
            s_d.mem[s_q.wr_ptr] = push_data;
            s_d.wr_ptr          = ptr_inc(s_q.wr_ptr);
        end
        case ({push_acc, pop_acc})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        if (s_q.count != '0) begin
            head_data = s_q.mem[s_q.rd_ptr];
        end else begin
            head_data = HOLD_LAST ? s_q.last : '0;
        end
    end

    assign count      = s_q.count;
    assign count_next = s_d.count;

endmodule

// File: rtl/afs_flags.sv
module afs_flags #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_cnt_q,
    input  logic [CW-1:0] tx_cnt_d,
    input  logic [CW-1:0] rx_cnt_d,
    input  logic          tx_push_ok,
    input  logic          tx_push_dma,
    input  logic [1:0]    tx_trig_sel,
    input  logic [1:0]    rx_trig_sel,
    input  logic          tde_clr_wr,
    input  logic          rdf_clr_wr,
    input  logic          unf_evt,
    input  logic          ovf_evt,
    output logic          tde,
    output logic          rdf,
    output logic          unf_pulse,
    output logic          ovf_pulse
);
    import afs_pkg::*;

    afs_flags_t f_q, f_d;
    int tx_thr, rx_thr;

    always_comb begin
        f_d    = f_q;
        tx_thr = int'(tx_thresh(tx_trig_sel));
        rx_thr = int'(rx_thresh(rx_trig_sel));

        // transmit-empty: level condition wins over any clear
        if (int'(tx_cnt_d) <= tx_thr) begin
            f_d.tde = 1'b1;
        end else if ((tde_clr_wr && (int'(tx_cnt_q) > tx_thr)) ||
                     (tx_push_ok && tx_push_dma)) begin
            f_d.tde = 1'b0;
        end

        // receive-full: level condition wins over a clear write
        if (int'(rx_cnt_d) >= rx_thr) begin
            f_d.rdf = 1'b1;
        end else if (rdf_clr_wr) begin
            f_d.rdf = 1'b0;
        end

        f_d.unf = unf_evt;
        f_d.ovf = ovf_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{tde: 1'b1, rdf: 1'b0, unf: 1'b0, ovf: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign tde       = f_q.tde;
    assign rdf       = f_q.rdf;
    assign unf_pulse = f_q.unf;
    assign ovf_pulse = f_q.ovf;

endmodule

// File: rtl/audio_fifo_status.sv
module audio_fifo_status #(
    parameter int W     = afs_pkg::WORD_W,
    parameter int DEPTH = afs_pkg::FIFO_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_tx_wr,
    input  logic         cpu_tx_dma,
    input  logic [W-1:0] cpu_tx_wdata,
    input  logic         cpu_rx_rd,
    output logic [W-1:0] cpu_rx_rdata,
    input  logic         stat_wr,
    input  logic [31:0]  stat_wdata,
    output logic [31:0]  stat_rdata,
    input  logic [1:0]   tx_trig_sel,
    input  logic [1:0]   rx_trig_sel,
    input  logic         ser_tx_pop,
    output logic [W-1:0] ser_tx_data,
    output logic         ser_tx_underflow,
    input  logic         ser_rx_push,
    input  logic [W-1:0] ser_rx_data,
    output logic         ser_rx_overflow,
    output logic         tx_req
);
    import afs_pkg::*;

    localparam logic [31:0] TDE_MASK = 32'(1) << TDE_BIT;
    localparam logic [31:0] RDF_MASK = 32'(1) << RDF_BIT;

    logic [CW-1:0] tx_cnt, tx_cnt_nx, rx_cnt, rx_cnt_nx;
    logic [31:0]   clr_mask;
    logic          tx_push_ok, tde_clr, rdf_clr, unf_evt, ovf_evt;
    logic          tde, rdf;

    afs_fifo #(.W(W), .DEPTH(DEPTH), .HOLD_LAST(1'b1)) u_txq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (cpu_tx_wr),
        .push_data  (cpu_tx_wdata),
        .pop        (ser_tx_pop),
        .head_data  (ser_tx_data),
        .count      (tx_cnt),
        .count_next (tx_cnt_nx)
    );

    afs_fifo #(.W(W), .DEPTH(DEPTH), .HOLD_LAST(1'b0)) u_rxq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (ser_rx_push),
        .push_data  (ser_rx_data),
        .pop        (cpu_rx_rd),
        .head_data  (cpu_rx_rdata),
        .count      (rx_cnt),
        .count_next (rx_cnt_nx)
    );

    always_comb begin
        clr_mask   = ~stat_wdata & (TDE_MASK | RDF_MASK);
        tde_clr    = stat_wr && ((clr_mask & TDE_MASK) != '0);
        rdf_clr    = stat_wr && ((clr_mask & RDF_MASK) != '0);
        tx_push_ok = cpu_tx_wr && (tx_cnt != CW'(DEPTH));
        unf_evt    = ser_tx_pop && (tx_cnt == '0);
        ovf_evt    = ser_rx_push && (rx_cnt == CW'(DEPTH));
    end

    afs_flags #(.CW(CW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_cnt_q    (tx_cnt),
        .tx_cnt_d    (tx_cnt_nx),
        .rx_cnt_d    (rx_cnt_nx),
        .tx_push_ok  (tx_push_ok),
        .tx_push_dma (cpu_tx_dma),
        .tx_trig_sel (tx_trig_sel),
        .rx_trig_sel (rx_trig_sel),
        .tde_clr_wr  (tde_clr),
        .rdf_clr_wr  (rdf_clr),
        .unf_evt     (unf_evt),
        .ovf_evt     (ovf_evt),
        .tde         (tde),
        .rdf         (rdf),
        .unf_pulse   (ser_tx_underflow),
        .ovf_pulse   (ser_rx_overflow)
    );

    always_comb begin
        stat_rdata = '0;
        stat_rdata[TXCNT_LSB +: FIELD_W] = FIELD_W'(tx_cnt);
        stat_rdata[RXCNT_LSB +: FIELD_W] = FIELD_W'(rx_cnt);
        stat_rdata[TDE_BIT] = tde;
        stat_rdata[RDF_BIT] = rdf;
    end

    assign tx_req = tde;

endmodule

// File: rtl/afs_chk.sv
module afs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_tx_wr,
    input logic        cpu_rx_rd,
    input logic        ser_tx_pop,
    input logic        ser_rx_push,
    input logic [1:0]  tx_trig_sel,
    input logic [1:0]  rx_trig_sel,
    input logic [31:0] stat_rdata,
    input logic        ser_tx_underflow,
    input logic        ser_rx_overflow
);
    import afs_pkg::*;

    logic [3:0] txc, rxc;
    assign txc = stat_rdata[27:24];
    assign rxc = stat_rdata[11:8];

    assert_tx_level_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
        txc <= 4'd8);

    assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (txc == 4'd8 && cpu_tx_wr && !ser_tx_pop) |=> (txc == 4'd8));

    assert_rx_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rxc == 4'd8 && !cpu_rx_rd) |=> (ser_rx_overflow && rxc == 4'd8));

    assert_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_tx_pop && txc == 4'd0) |=> (ser_tx_underflow && txc <= 4'd1));

    assert_no_spurious_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_tx_pop && txc == 4'd0) |=> !ser_tx_underflow);

    assert_tde_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txc <= tx_thresh(tx_trig_sel) && !cpu_tx_wr) |=> stat_rdata[16]);

    assert_rdf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rxc >= rx_thresh(rx_trig_sel) && !cpu_rx_rd) |=> stat_rdata[0]);

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata & 32'hF0FE_F0FE) == 32'h0);

endmodule

bind audio_fifo_status afs_chk u_chk (.*);

// File: tb/audio_fifo_status_bench.sv
`timescale 1ns/1ps
module audio_fifo_status_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_tx_wr = 0, cpu_tx_dma = 0, cpu_rx_rd = 0, stat_wr = 0;
    logic        ser_tx_pop = 0, ser_rx_push = 0;
    logic [31:0] cpu_tx_wdata = 0, stat_wdata = 0, ser_rx_data = 0;
    logic [1:0]  tx_trig_sel = 0, rx_trig_sel = 0;
    logic [31:0] cpu_rx_rdata, stat_rdata, ser_tx_data;
    logic        ser_tx_underflow, ser_rx_overflow, tx_req;

    always #2.5 clk = ~clk;

    audio_fifo_status u_audio_fifo_status (.*);

    int vectors = 0, fails = 0;
    bit done = 0;

    // reference model
    logic [31:0] txq[$], rxq[$];
    logic [31:0] m_last = 0;
    bit m_tde = 1, m_rdf = 0, m_unf = 0, m_ovf = 0;
    string tag_txc = "R1", tag_rxc = "R3", tag_tde = "R6";

    function automatic int tx_thr(input logic [1:0] s);
        case (s) 0: return 7; 1: return 6; 2: return 4; default: return 2; endcase
    endfunction
    function automatic int rx_thr(input logic [1:0] s);
        case (s) 0: return 1; 1: return 2; 2: return 4; default: return 6; endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all();
        int n = txq.size();
        int m = rxq.size();
        chk(tag_txc, "tx count", 32'(stat_rdata[27:24]), 32'(n));
        chk(tag_rxc, "rx count", 32'(stat_rdata[11:8]), 32'(m));
        chk(tag_tde, "tx empty flag", 32'(stat_rdata[16]), 32'(m_tde));
        chk("R10", "rx full flag", 32'(stat_rdata[0]), 32'(m_rdf));
        chk("R11", "reserved bits", stat_rdata & 32'hF0FE_F0FE, 32'h0);
        chk("R9", "tx_req", 32'(tx_req), 32'(stat_rdata[16]));
        if (n > 0) chk("R1", "tx head", ser_tx_data, txq[0]);
        else       chk("R5", "tx head when empty", ser_tx_data, m_last);
        chk("R3", "rx head", cpu_rx_rdata, (m > 0) ? rxq[0] : 32'h0);
        chk("R5", "underflow pulse", 32'(ser_tx_underflow), 32'(m_unf));
        chk("R4", "overflow pulse", 32'(ser_rx_overflow), 32'(m_ovf));
    endtask

    // one clock: model next state from presented inputs, then compare
    task automatic cycle();
        int n = txq.size();
        int m = rxq.size();
        bit push_ok = cpu_tx_wr && n < 8;
        bit pop_ok  = ser_tx_pop && n > 0;
        bit rpush   = ser_rx_push && m < 8;
        bit rpop    = cpu_rx_rd && m > 0;
        tag_txc = (cpu_tx_wr && n == 8) ? "R2" : "R1";
        tag_rxc = (ser_rx_push && m == 8) ? "R4" : "R3";
        tag_tde = "R6";
        m_unf = ser_tx_pop && n == 0;
        m_ovf = ser_rx_push && m == 8;
        if (pop_ok) m_last = txq.pop_front();
        if (push_ok) txq.push_back(cpu_tx_wdata);
        if (rpop) void'(rxq.pop_front());
        if (rpush) rxq.push_back(ser_rx_data);
        if (txq.size() <= tx_thr(tx_trig_sel)) m_tde = 1;
        else if (stat_wr && !stat_wdata[16] && n > tx_thr(tx_trig_sel)) begin
            m_tde = 0; tag_tde = "R7";
        end else if (push_ok && cpu_tx_dma) begin
            m_tde = 0; tag_tde = "R8";
        end else if (stat_wr) tag_tde = "R7";
        if (rxq.size() >= rx_thr(rx_trig_sel)) m_rdf = 1;
        else if (stat_wr && !stat_wdata[0]) m_rdf = 0;
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        cpu_tx_wr = 0; cpu_tx_dma = 0; cpu_rx_rd = 0; stat_wr = 0;
        ser_tx_pop = 0; ser_rx_push = 0;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state: R6 flag set, R10 flag clear, counts zero
        check_all();
        rst_n = 1;
        @(negedge clk);

        // R2: fill past full with threshold 4
        tx_trig_sel = 2;
        for (int i = 0; i < 10; i++) begin
            idle(); cpu_tx_wr = 1; cpu_tx_wdata = 32'hA000_0000 + i;
            if (i == 2) begin stat_wr = 1; stat_wdata = 32'h0; end  // R7 too early
            cycle();
        end
        // R7: writing 1 keeps, writing 0 clears, then writing 1 after clear keeps 0
        idle(); stat_wr = 1; stat_wdata = 32'hFFFF_FFFF; cycle();
        idle(); stat_wr = 1; stat_wdata = 32'hFFFE_FFFF; cycle();
        idle(); stat_wr = 1; stat_wdata = 32'h0001_0001; cycle();
        // R6, R5: drain and underflow
        for (int i = 0; i < 10; i++) begin idle(); ser_tx_pop = 1; cycle(); end
        idle(); cycle();
        // R8: DMA refill with threshold 2
        tx_trig_sel = 3;
        for (int i = 0; i < 4; i++) begin
            idle(); cpu_tx_wr = 1; cpu_tx_dma = 1; cpu_tx_wdata = 32'hD000_0000 + i; cycle();
        end
        // R6: raise threshold while idle -> flag sets on next clock
        tx_trig_sel = 0; idle(); cycle();
        // R4, R10: receive overflow with threshold 4
        rx_trig_sel = 2;
        for (int i = 0; i < 10; i++) begin
            idle(); ser_rx_push = 1; ser_rx_data = 32'h5500_0000 + i; cycle();
        end
        for (int i = 0; i < 10; i++) begin
            idle(); cpu_rx_rd = 1;
            if (i > 6) begin stat_wr = 1; stat_wdata = 32'h0; end
            cycle();
        end

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            idle();
            cpu_tx_wr   = ($urandom % 3) == 0;
            cpu_tx_dma  = ($urandom % 2) == 0;
            cpu_tx_wdata = $urandom;
            ser_tx_pop  = ($urandom % 3) == 0;
            ser_rx_push = ($urandom % 3) == 0;
            ser_rx_data = $urandom;
            cpu_rx_rd   = ($urandom % 3) == 0;
            stat_wr     = ($urandom % 8) == 0;
            stat_wdata  = $urandom;
            if (($urandom % 64) == 0) tx_trig_sel = 2'($urandom);
            if (($urandom % 64) == 0) rx_trig_sel = 2'($urandom);
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule